// File: doc/BRIEF.md
# Trap CSR Write and Legalize Unit

This block keeps the trap-handling control and status registers of a processor hart for the machine and supervisor privilege levels. For each level it holds the exception PC, the scratch word, the cause and the trap value. It also holds the two trap-vector registers, the machine interrupt-enable and interrupt-pending registers, and the supervisor interrupt-enable register. Software stores arrive on a single write port: a 12-bit CSR address, a data word and a strobe. Each store is sent to one of several write legalizers. Exception-PC stores are aligned, and how far depends on whether compressed instructions are enabled. Trap-vector stores refuse a reserved mode. Interrupt-register stores only change the bits that are allowed to change.

A combinational read port returns any held register by its address. The block also looks at the ISA word, the current privilege level and two 2-bit width fields from the status register. From these it derives the effective architecture width and a set of extension flags. A store to an address that the block does not map leaves every register untouched and raises a one-cycle illegal-access pulse.

Top module: `trap_csr_unit`

## Requirements
- R1: After reset every held register reads back as zero and `illegal_wr` is low.
- R2: A store to 0x340, 0x342, 0x343, 0x140, 0x142, 0x143 or 0x104 keeps the whole data word, and the word reads back at the same address.
- R3: A store to 0x341 or 0x141 keeps the data with bit 0 cleared when ISA bit 2 (compressed) is set, and with bits 1:0 cleared when it is clear.
- R4: For a store to 0x305 or 0x105, data bits 1:0 are the mode. A mode of 0 or 1 is stored with the word as given. A mode of 2 or 3 stores bits XLEN-1:2 of the data and keeps the previous mode bits.
- R5: A store to 0x304 changes only the bits set in the enable mask (default 0xAAA). A store to 0x344 changes only the bits set in the pending mask (default 0x222). All other bits keep their old value.
- R6: A store to 0x144 writes the whole word into the machine pending register, which reads back at both 0x344 and 0x144.
- R7: A store to an unmapped address changes no register. `illegal_wr` is high during exactly the one cycle after the strobe was sampled.
- R8: A store becomes visible on `rd_data` after the clock edge that samples the strobe. When no store is made and `rd_addr` does not change, `rd_data` does not change.
- R9: The width field is chosen by `priv`. 2'b11 (machine) uses ISA bits XLEN-1:XLEN-2, 2'b01 (supervisor) uses `sxl`, and 2'b00 (user) uses `uxl`.
- R10: `arch_code` equals the chosen field when that field is 01 (32-bit), 10 (64-bit) or 11 (128-bit). A field of 00, or `priv` equal to 2'b10, drives `arch_err` high and `arch_code` to 00.
- R11: `mode32` is high exactly when `arch_code` is 01 and `arch_err` is low.
- R12: The extension flags follow the ISA word. `has_amo` is bit 0, `has_rvc` is bit 2, `has_muldiv` is bit 12, and `has_fp` is bit 3 OR bit 5.
- R13: Reading an unmapped address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write CSR address |
| wr_data | input | XLEN | Write data |
| rd_addr | input | 12 | Read CSR address |
| rd_data | output | XLEN | Readback data, combinational |
| isa_word | input | XLEN | ISA register contents |
| priv | input | 2 | Current privilege level |
| sxl | input | 2 | Supervisor width field |
| uxl | input | 2 | User width field |
| illegal_wr | output | 1 | One-cycle pulse after an unmapped store |
| arch_code | output | 2 | Effective width encoding |
| mode32 | output | 1 | Effective width is 32-bit |
| arch_err | output | 1 | Reserved width or privilege encoding |
| has_amo | output | 1 | Atomics enabled |
| has_rvc | output | 1 | Compressed enabled |
| has_muldiv | output | 1 | Multiply/divide enabled |
| has_fp | output | 1 | Floating point enabled |

## Verification
Each store is followed by a readback of all fourteen mapped addresses, so any corruption in a register shows up on `rd_data` one cycle after the strobe. This covers a wrong legalizer choice, a wrong slot, a stray write and a decode alias. Wrong alignment shows as a low address bit that is set, and a leaked reserved vector mode shows as bit 1 set. The width selection is purely combinational. A wrong field choice or a wrong reserved decode therefore shows on `arch_code`, `arch_err` and `mode32` in the same cycle that the inputs change.

// File: rtl/trap_csr_pkg.sv
package trap_csr_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_STORE = 3'd1,
        OP_EPC   = 3'd2,
        OP_TVEC  = 3'd3,
        OP_IE    = 3'd4,
        OP_IP    = 3'd5
    } wr_op_e;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'b00,
        PRIV_SUPER = 2'b01,
        PRIV_RSVD  = 2'b10,
        PRIV_MACH  = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        ARCH_NONE = 2'b00,
        ARCH_W32  = 2'b01,
        ARCH_W64  = 2'b10,
        ARCH_W128 = 2'b11
    } arch_e;

    localparam int NSLOT  = 13;
    localparam int SLOT_W = $clog2(NSLOT);

    localparam logic [SLOT_W-1:0] SL_M_EPC   = 4'd0;
    localparam logic [SLOT_W-1:0] SL_M_SCR   = 4'd1;
    localparam logic [SLOT_W-1:0] SL_M_CAUSE = 4'd2;
    localparam logic [SLOT_W-1:0] SL_M_TVAL  = 4'd3;
    localparam logic [SLOT_W-1:0] SL_S_EPC   = 4'd4;
    localparam logic [SLOT_W-1:0] SL_S_SCR   = 4'd5;
    localparam logic [SLOT_W-1:0] SL_S_CAUSE = 4'd6;
    localparam logic [SLOT_W-1:0] SL_S_TVAL  = 4'd7;
    localparam logic [SLOT_W-1:0] SL_M_VEC   = 4'd8;
    localparam logic [SLOT_W-1:0] SL_S_VEC   = 4'd9;
    localparam logic [SLOT_W-1:0] SL_M_IE    = 4'd10;
    localparam logic [SLOT_W-1:0] SL_M_IP    = 4'd11;
    localparam logic [SLOT_W-1:0] SL_S_IE    = 4'd12;

    localparam int ISA_BIT_A = 0;
    localparam int ISA_BIT_C = 2;
    localparam int ISA_BIT_D = 3;
    localparam int ISA_BIT_F = 5;
    localparam int ISA_BIT_M = 12;

    typedef struct packed {
        logic              hit;
        wr_op_e            op;
        logic [SLOT_W-1:0] slot;
    } csr_dec_t;

endpackage

// File: rtl/trap_csr_decode.sv
module trap_csr_decode
    import trap_csr_pkg::*;
(
    input  logic [11:0] addr,
    output csr_dec_t    dec
);
    always_comb begin
        dec = '{hit: 1'b1, op: OP_STORE, slot: SL_M_SCR};
        case (addr)
            12'h340: dec = '{hit: 1'b1, op: OP_STORE, slot: SL_M_SCR};
            12'h341: dec = '{hit: 1'b1, op: OP_EPC,   slot: SL_M_EPC};
            12'h342: dec = '{hit: 1'b1, op: OP_STORE, slot: SL_M_CAUSE};
            12'h343: dec = '{hit: 1'b1, op: OP_STORE, slot: SL_M_TVAL};
            12'h140: dec = '{hit: 1'b1, op: OP_STORE, slot: SL_S_SCR};
            12'h141: dec = '{hit: 1'b1, op: OP_EPC,   slot: SL_S_EPC};
            12'h142: dec = '{hit: 1'b1, op: OP_STORE, slot: SL_S_CAUSE};
            12'h143: dec = '{hit: 1'b1, op: OP_STORE, slot: SL_S_TVAL};
            12'h305: dec = '{hit: 1'b1, op: OP_TVEC,  slot: SL_M_VEC};
            12'h105: dec = '{hit: 1'b1, op: OP_TVEC,  slot: SL_S_VEC};
            12'h304: dec = '{hit: 1'b1, op: OP_IE,    slot: SL_M_IE};
            12'h344: dec = '{hit: 1'b1, op: OP_IP,    slot: SL_M_IP};
            12'h144: dec = '{hit: 1'b1, op: OP_STORE, slot: SL_M_IP};
            12'h104: dec = '{hit: 1'b1, op: OP_STORE, slot: SL_S_IE};
            default: dec = '{hit: 1'b0, op: OP_NONE,  slot: '0};
        endcase
    end
endmodule

// File: rtl/trap_csr_legalize.sv
module trap_csr_legalize
    import trap_csr_pkg::*;
#(
    parameter int              XLEN    = 64,
    parameter logic [XLEN-1:0] IE_MASK = XLEN'('hAAA),
    parameter logic [XLEN-1:0] IP_MASK = XLEN'('h222)
) (
    input  wr_op_e          op,
    input  logic [XLEN-1:0] wdata,
    input  logic [XLEN-1:0] old,
    input  logic            rvc_on,
    output logic [XLEN-1:0] nxt
);
    localparam logic [XLEN-1:0] EPC_KEEP_C = ~XLEN'(1);
    localparam logic [XLEN-1:0] EPC_KEEP_N = ~XLEN'(3);

    logic [1:0] mode_in;
    assign mode_in = wdata[1:0];

    always_comb begin
        nxt = old;
        unique case (op)
            OP_STORE: nxt = wdata;
            OP_EPC:   nxt = wdata & (rvc_on ? EPC_KEEP_C : EPC_KEEP_N);
            OP_TVEC:  nxt = mode_in[1] ? {wdata[XLEN-1:2], old[1:0]} : wdata;
            OP_IE:    nxt = (old & ~IE_MASK) | (wdata & IE_MASK);
            OP_IP:    nxt = (old & ~IP_MASK) | (wdata & IP_MASK);
            default:  nxt = old;
        endcase
    end
endmodule

// File: rtl/trap_xlen_sel.sv
module trap_xlen_sel
    import trap_csr_pkg::*;
(
    input  logic [1:0] mxl,
    input  logic [1:0] sxl,
    input  logic [1:0] uxl,
    input  logic [1:0] priv,
    output logic [1:0] arch_code,
    output logic       mode32,
    output logic       arch_err
);
    logic [1:0] field;
    logic       priv_bad;

    always_comb begin
        priv_bad = 1'b0;
        field    = 2'b00;
        unique case (priv_e'(priv))
            PRIV_MACH:  field = mxl;
            PRIV_SUPER: field = sxl;
            PRIV_USER:  field = uxl;
            PRIV_RSVD:  priv_bad = 1'b1;
            default:    priv_bad = 1'b1;
        endcase
    end

    always_comb begin
        arch_err  = 1'b0;
        arch_code = ARCH_NONE;
        if (priv_bad) begin
            arch_err = 1'b1;
        end else begin
            unique case (arch_e'(field))
                ARCH_W32:  arch_code = ARCH_W32;
                ARCH_W64:  arch_code = ARCH_W64;
                ARCH_W128: arch_code = ARCH_W128;
                default:   arch_err  = 1'b1;
            endcase
        end
    end

    assign mode32 = (arch_code == ARCH_W32) && !arch_err;
endmodule

// File: rtl/trap_csr_unit.sv
module trap_csr_unit
    import trap_csr_pkg::*;
#(
    parameter int              XLEN    = 64,
    parameter logic [XLEN-1:0] IE_MASK = XLEN'('hAAA),
    parameter logic [XLEN-1:0] IP_MASK = XLEN'('h222)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [11:0]     wr_addr,
    input  logic [XLEN-1:0] wr_data,
    input  logic [11:0]     rd_addr,
    output logic [XLEN-1:0] rd_data,
    input  logic [XLEN-1:0] isa_word,
    input  logic [1:0]      priv,
    input  logic [1:0]      sxl,
    input  logic [1:0]      uxl,
    output logic            illegal_wr,
    output logic [1:0]      arch_code,
    output logic            mode32,
    output logic            arch_err,
    output logic            has_amo,
    output logic            has_rvc,
    output logic            has_muldiv,
    output logic            has_fp
);
    csr_dec_t        wdec;
    csr_dec_t        rdec;
    logic [XLEN-1:0] regs [NSLOT];
    logic [XLEN-1:0] old_val;
    logic [XLEN-1:0] new_val;

    trap_csr_decode u_wdec (.addr(wr_addr), .dec(wdec));
    trap_csr_decode u_rdec (.addr(rd_addr), .dec(rdec));

    assign has_amo    = isa_word[ISA_BIT_A];
    assign has_rvc    = isa_word[ISA_BIT_C];
    assign has_muldiv = isa_word[ISA_BIT_M];
    assign has_fp     = isa_word[ISA_BIT_F] | isa_word[ISA_BIT_D];

    assign old_val = regs[wdec.slot];

    trap_csr_legalize #(
        .XLEN(XLEN), .IE_MASK(IE_MASK), .IP_MASK(IP_MASK)
    ) u_leg (
        .op(wdec.op), .wdata(wr_data), .old(old_val),
        .rvc_on(has_rvc), .nxt(new_val)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) regs[i] <= '0;
            illegal_wr <= 1'b0;
        end else begin
            illegal_wr <= wr_en && !wdec.hit;
            if (wr_en && wdec.hit) regs[wdec.slot] <= new_val;
        end
    end

    assign rd_data = rdec.hit ? regs[rdec.slot] : '0;

    trap_xlen_sel u_xsel (
        .mxl(isa_word[XLEN-1:XLEN-2]), .sxl(sxl), .uxl(uxl), .priv(priv),
        .arch_code(arch_code), .mode32(mode32), .arch_err(arch_err)
    );
endmodule

// File: rtl/trap_csr_chk.sv
module trap_csr_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [11:0]     wr_addr,
    input logic [11:0]     rd_addr,
    input logic [XLEN-1:0] rd_data,
    input logic            illegal_wr,
    input logic [1:0]      arch_code,
    input logic            mode32,
    input logic            arch_err
);
    function automatic logic mapped(input logic [11:0] a);
        return (a inside {12'h340, 12'h341, 12'h342, 12'h343, 12'h140, 12'h141,
                          12'h142, 12'h143, 12'h305, 12'h105, 12'h304, 12'h344,
                          12'h144, 12'h104});
    endfunction

    // R7
    illegal_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_wr |-> ($past(wr_en) && !mapped($past(wr_addr))));

    // R7
    illegal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mapped(wr_addr)) |=> illegal_wr);

    // R3
    epc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 12'h341 || rd_addr == 12'h141) |-> !rd_data[0]);

    // R4
    vec_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 12'h305 || rd_addr == 12'h105) |-> !rd_data[1]);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (!$stable(rd_addr) || $stable(rd_data)));

    // R11
    mode32_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode32 |-> (arch_code == 2'b01 && !arch_err));

    // R10
    err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arch_err |-> (arch_code == 2'b00 && !mode32));

    // R13
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped(rd_addr) |-> (rd_data == '0));
endmodule

bind trap_csr_unit trap_csr_chk #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_addr(rd_addr), .rd_data(rd_data), .illegal_wr(illegal_wr),
    .arch_code(arch_code), .mode32(mode32), .arch_err(arch_err)
);

// File: tb/trap_csr_unit_tb.sv
`timescale 1ns/100ps
module trap_csr_unit_tb;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [11:0]     wr_addr = '0;
    logic [XLEN-1:0] wr_data = '0;
    logic [11:0]     rd_addr = '0;
    logic [XLEN-1:0] rd_data;
    logic [XLEN-1:0] isa_word = '0;
    logic [1:0]      priv = 2'b11;
    logic [1:0]      sxl = 2'b10;
    logic [1:0]      uxl = 2'b10;
    logic            illegal_wr, mode32, arch_err;
    logic [1:0]      arch_code;
    logic            has_amo, has_rvc, has_muldiv, has_fp;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 0;

    always #2.5 clk = ~clk;

    trap_csr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .isa_word(isa_word), .priv(priv), .sxl(sxl), .uxl(uxl),
        .illegal_wr(illegal_wr), .arch_code(arch_code), .mode32(mode32),
        .arch_err(arch_err), .has_amo(has_amo), .has_rvc(has_rvc),
        .has_muldiv(has_muldiv), .has_fp(has_fp)
    );

    localparam logic [11:0] ADDRS [13] = '{12'h341, 12'h340, 12'h342, 12'h343,
        12'h141, 12'h140, 12'h142, 12'h143, 12'h305, 12'h105, 12'h304,
        12'h344, 12'h104};
    localparam int IDX_IP = 11;
    logic [XLEN-1:0] model [13];

    task automatic check(input string tag, input logic [XLEN-1:0] got,
                         input logic [XLEN-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic int idx_of(input logic [11:0] a);
        if (a == 12'h144) return IDX_IP;
        for (int i = 0; i < 13; i++) if (ADDRS[i] == a) return i;
        return -1;
    endfunction

    function automatic logic [XLEN-1:0] expect_nxt(input logic [11:0] a,
        input logic [XLEN-1:0] d, input logic [XLEN-1:0] o, input logic c);
        case (a)
            12'h341, 12'h141: return c ? (d & ~64'd1) : (d & ~64'd3);
            12'h305, 12'h105: return (d[1:0] >= 2) ? {d[XLEN-1:2], o[1:0]} : d;
            12'h304: return (o & ~64'hAAA) | (d & 64'hAAA);
            12'h344: return (o & ~64'h222) | (d & 64'h222);
            default: return d;
        endcase
    endfunction

    task automatic read_all(input string tag);
        for (int i = 0; i < 13; i++) begin
            rd_addr = ADDRS[i];
            #0.1;
            check($sformatf("%s rd %h", tag, ADDRS[i]), rd_data, model[i]);
        end
        rd_addr = 12'h144;
        #0.1;
        check($sformatf("%s R6 rd 144", tag), rd_data, model[IDX_IP]);
    endtask

    task automatic do_write(input logic [11:0] a, input logic [XLEN-1:0] d,
                            input string tag);
        int k;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        k = idx_of(a);
        if (k >= 0) model[k] = expect_nxt(a, d, model[k], isa_word[2]);
        check($sformatf("%s illegal_wr after %h", tag, a), {63'd0, illegal_wr},
              {63'd0, (k < 0)});
        read_all(tag);
        @(negedge clk);
        check($sformatf("%s R7 pulse ends", tag), {63'd0, illegal_wr}, '0);
    endtask

    localparam logic [XLEN-1:0] PATS [6] = '{64'hDEAD_BEEF_1234_5677,
        64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDE6, 64'h8000_0000_0000_0005,
        64'h0000_0000_0000_0FFC, 64'h5A5A_A5A5_0F0F_F0F1};

    initial begin
        for (int i = 0; i < 13; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 illegal_wr", {63'd0, illegal_wr}, '0);
        read_all("R1");

        // R2 R3 R4 R5 R6 R8: sweep addresses, patterns, compressed on/off
        for (int c = 0; c < 2; c++) begin
            isa_word = {2'b10, 62'd0} | (c ? 64'd4 : 64'd0);
            for (int p = 0; p < 6; p++) begin
                for (int i = 0; i < 13; i++) do_write(ADDRS[i], PATS[p], "R2/R3/R4/R5");
                do_write(12'h144, PATS[p] ^ 64'h333, "R6");
            end
        end
        // R4 reserved modes keep previous mode
        do_write(12'h305, 64'h1000_0001, "R4 set");
        do_write(12'h305, 64'h2000_0003, "R4 rsvd3");
        do_write(12'h105, 64'h3000_0002, "R4 rsvd2");

        // R7 R13 unmapped stores and reads
        foreach (PATS[p]) begin
            do_write(12'h300, PATS[p], "R7");
            do_write(12'h345, PATS[p], "R7");
            do_write(12'h241, PATS[p], "R7");
            do_write(12'hFFF, PATS[p], "R7");
        end
        foreach (PATS[p]) begin
            rd_addr = (p % 2) ? 12'h000 : 12'h106 + 12'(p);
            #0.1;
            check("R13 unmapped read", rd_data, '0);
        end

        // R9 R10 R11 width selection sweep
        for (int p = 0; p < 4; p++) begin
            for (int f = 0; f < 4; f++) begin
                logic [1:0] sel;
                logic       e_err;
                logic [1:0] e_code;
                isa_word[63:62] = 2'(f);
                sxl = 2'(f + 1);
                uxl = 2'(f + 2);
                sel = (p == 3) ? 2'(f) : (p == 1) ? 2'(f + 1) : 2'(f + 2);
                e_err = (p == 2) || (sel == 2'b00);
                e_code = e_err ? 2'b00 : sel;
                priv = 2'(p);
                #0.2;
                check($sformatf("R9 code p=%0d f=%0d", p, f), {62'd0, arch_code}, {62'd0, e_code});
                check($sformatf("R10 err p=%0d f=%0d", p, f), {63'd0, arch_err}, {63'd0, e_err});
                check($sformatf("R11 mode32 p=%0d f=%0d", p, f), {63'd0, mode32},
                      {63'd0, (e_code == 2'b01)});
            end
        end

        // R12 extension flags
        for (int k = 0; k < 32; k++) begin
            isa_word = '0;
            isa_word[0] = k[0]; isa_word[2] = k[1]; isa_word[3] = k[2];
            isa_word[5] = k[3]; isa_word[12] = k[4];
            #0.2;
            check("R12 amo", {63'd0, has_amo}, {63'd0, k[0]});
            check("R12 rvc", {63'd0, has_rvc}, {63'd0, k[1]});
            check("R12 muldiv", {63'd0, has_muldiv}, {63'd0, k[4]});
            check("R12 fp", {63'd0, has_fp}, {63'd0, (k[2] | k[3])});
        end

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule